// File: doc/BRIEF.md
# Clear-Channel Threshold Interrupt Filter

This block watches the clear (unfiltered) light result of a colour sensor. It judges that result once per measurement cycle, at the point where the measurement engine pulses `cycle_done`. A result counts as outside the window when it lies strictly below the low bound or strictly above the high bound. The block counts how many such results arrive back to back. When that run reaches the length chosen by a 4-bit persistence code, it sets a sticky interrupt status flag.

The persistence code does not map to run lengths in a straight line. Codes 1 to 3 ask for that many consecutive outside results. From code 4 upward the required run grows in steps of five, up to sixty. Code 0 sets the flag on every completed cycle, whatever the result. A single result inside the window throws the run away. The flag stays set until a clear strobe arrives, and that strobe also empties the run counter. The active-low interrupt pin follows the flag only while the interrupt-enable input is high. The colour channels are not inputs to this block, so they can never cause an interrupt.

Top module: `thr_persist_filter`

## Requirements
- R1: Synchronous reset leaves `int_status` at 0, `int_n` at 1 and the run counter at zero, so a run started before reset does not carry over.
- R2: A result is outside the window when `clear_value < thr_low` or `clear_value > thr_high`. A value equal to either bound is inside.
- R3: With code c, the flag sets on the c-th consecutive outside result for c = 1..3, and on the 5*(c-3)-th for c = 4..15. The required lengths are 1, 2, 3, 5, 10, 15, 20, 25, 30, 35, 40, 45, 50, 55, 60, and the run count never exceeds 60.
- R4: With code 0, every cycle with `cycle_done` high sets the flag, whatever the value and thresholds.
- R5: A cycle whose result is inside the window resets the run count to zero and leaves the flag unchanged.
- R6: Once set, `int_status` stays high on later cycles, including inside-window ones, until `clr_strobe`.
- R7: `clr_strobe` clears the flag and the run counter at the next clock edge. It wins over a `cycle_done` in the same clock, whose result is then discarded.
- R8: `int_n` is 0 exactly when `int_status` is 1 and `int_en` is 1. `int_en` has no effect on the flag or the counter.
- R9: In a clock with `cycle_done` low, `clear_value` and the thresholds are ignored, and neither the flag nor the count changes.
- R10: Changing the code keeps the current run count. The next outside result trips the flag if the count then reaches or passes the new required length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cycle_done | input | 1 | One-clock pulse marking a finished measurement cycle |
| clear_value | input | 16 | Clear-channel result of that cycle |
| thr_low | input | 16 | Low window bound |
| thr_high | input | 16 | High window bound |
| pers_code | input | 4 | Persistence code |
| int_en | input | 1 | Interrupt pin enable |
| clr_strobe | input | 1 | Clears flag and run counter |
| int_status | output | 1 | Sticky interrupt status flag |
| int_n | output | 1 | Active-low interrupt pin |

## Verification
The properties assume that `cycle_done` and `clr_strobe` are sampled once per clock and that every input is stable around the rising edge. They also assume that the code is held steady during a cycle in which code-0 behaviour is checked. The stimulus changes every input only on the falling edge and returns the strobes to low right after the edge that consumes them. It keeps `thr_low` no greater than `thr_high`, so that the window is never empty and an in-window value always exists.

// File: rtl/thr_persist_pkg.sv
package thr_persist_pkg;

    localparam int VAL_W  = 16;
    localparam int PERS_W = 4;
    localparam int CNT_W  = 6;
    localparam int LINEAR_CODES = 4;
    localparam int STEP_LEN     = 5;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [PERS_W-1:0] pers_t;

    typedef struct packed {
        logic valid;
        logic below;
        logic above;
        logic outside;
    } sample_eval_t;

    function automatic cnt_t pers_target(input pers_t code);
        cnt_t r;
        if (int'(code) < LINEAR_CODES)
            r = cnt_t'(code);
        else
            r = cnt_t'(STEP_LEN * (int'(code) - (LINEAR_CODES - 1)));
        return r;
    endfunction

endpackage

// File: rtl/tpf_window.sv
module tpf_window
    import thr_persist_pkg::*;
#(
    parameter int W = VAL_W
) (
    input  logic         cyc_done,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] lo,
    input  logic [W-1:0] hi,
    output sample_eval_t ev
);
    always_comb begin
        ev.valid   = cyc_done;
        ev.below   = sample < lo;
        ev.above   = sample > hi;
        ev.outside = ev.below | ev.above;
    end
endmodule

// File: rtl/tpf_persist.sv
module tpf_persist
    import thr_persist_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  sample_eval_t ev,
    input  pers_t        code,
    output cnt_t         run_cnt,
    output logic         trip
);
    cnt_t target;
    cnt_t bumped;
    cnt_t cnt_nxt;

    always_comb begin
        target  = pers_target(code);
        bumped  = (run_cnt >= target) ? target : cnt_t'(run_cnt + 1'b1);
        cnt_nxt = run_cnt;
        trip    = 1'b0;
        if (clr) begin
            cnt_nxt = '0;
        end else if (ev.valid) begin
            if (target == '0) begin
                cnt_nxt = '0;
                trip    = 1'b1;
            end else if (ev.outside) begin
                cnt_nxt = bumped;
                trip    = (bumped >= target);
            end else begin
                cnt_nxt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) run_cnt <= '0;
        else     run_cnt <= cnt_nxt;
    end
endmodule

// File: rtl/tpf_irq.sv
module tpf_irq (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic trip,
    input  logic en,
    output logic status,
    output logic pin_n
);
    always_ff @(posedge clk) begin
        if (rst)       status <= 1'b0;
        else if (clr)  status <= 1'b0;
        else if (trip) status <= 1'b1;
    end

    assign pin_n = ~(status & en);
endmodule

// File: rtl/thr_persist_filter.sv
module thr_persist_filter
    import thr_persist_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cycle_done,
    input  logic [VAL_W-1:0] clear_value,
    input  logic [VAL_W-1:0] thr_low,
    input  logic [VAL_W-1:0] thr_high,
    input  logic [PERS_W-1:0] pers_code,
    input  logic             int_en,
    input  logic             clr_strobe,
    output logic             int_status,
    output logic             int_n
);
    sample_eval_t ev;
    cnt_t         run_cnt;
    logic         trip;

    tpf_window #(.W(VAL_W)) u_win (
        .cyc_done (cycle_done),
        .sample   (clear_value),
        .lo       (thr_low),
        .hi       (thr_high),
        .ev       (ev)
    );

    tpf_persist u_pers (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr_strobe),
        .ev      (ev),
        .code    (pers_code),
        .run_cnt (run_cnt),
        .trip    (trip)
    );

    tpf_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_strobe),
        .trip   (trip),
        .en     (int_en),
        .status (int_status),
        .pin_n  (int_n)
    );
endmodule

// File: rtl/tpf_checker.sv
module tpf_checker
    import thr_persist_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        cycle_done,
    input logic        clr_strobe,
    input logic [PERS_W-1:0] pers_code,
    input logic        int_en,
    input logic        int_status,
    input logic        int_n,
    input logic [CNT_W-1:0] run_cnt
);
    assert_pin_off_R8: assert property (@(posedge clk) disable iff (rst)
        !int_en |-> int_n);

    assert_pin_on_R8: assert property (@(posedge clk) disable iff (rst)
        (int_status && int_en) |-> !int_n);

    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clr_strobe |=> (!int_status && run_cnt == '0));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (int_status && !clr_strobe) |=> int_status);

    assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!cycle_done && !clr_strobe) |=> ($stable(int_status) && $stable(run_cnt)));

    assert_every_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (cycle_done && !clr_strobe && pers_code == '0) |=> int_status);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        run_cnt <= CNT_W'(60));
endmodule

bind thr_persist_filter tpf_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cycle_done (cycle_done),
    .clr_strobe (clr_strobe),
    .pers_code  (pers_code),
    .int_en     (int_en),
    .int_status (int_status),
    .int_n      (int_n),
    .run_cnt    (run_cnt)
);

// File: tb/sim_thr_persist_filter.sv
module sim_thr_persist_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cycle_done = 1'b0;
    logic [15:0] clear_value = '0;
    logic [15:0] thr_low = 16'd100;
    logic [15:0] thr_high = 16'd200;
    logic [3:0]  pers_code = '0;
    logic        int_en = 1'b0;
    logic        clr_strobe = 1'b0;
    logic        int_status;
    logic        int_n;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    thr_persist_filter u0 (
        .clk(clk), .rst(rst), .cycle_done(cycle_done), .clear_value(clear_value),
        .thr_low(thr_low), .thr_high(thr_high), .pers_code(pers_code),
        .int_en(int_en), .clr_strobe(clr_strobe),
        .int_status(int_status), .int_n(int_n)
    );

    // vector: {cd, clr, value[15:0], code[3:0], en, exp_status, exp_int_n}
    localparam int NV = 20;
    function automatic logic [24:0] vec(input logic cd, input logic cl, input int v,
                                        input int c, input logic en, input logic st, input logic n);
        return {cd, cl, 16'(v), 4'(c), en, st, n};
    endfunction

    localparam logic [24:0] VEC [NV] = '{
        vec(0,1,  0,1,1,0,1),  // R7 clear from idle
        vec(1,0,150,1,1,0,1),  // R2 inside
        vec(1,0,100,1,1,0,1),  // R2 equals low
        vec(1,0,200,1,1,0,1),  // R2 equals high
        vec(1,0,201,1,1,1,0),  // R2 above high
        vec(1,0,150,1,1,1,0),  // R6 sticky
        vec(0,0,150,1,0,1,1),  // R8 pin masked
        vec(0,1,150,1,0,0,1),  // R7 clear
        vec(1,0, 99,2,1,0,1),  // R3 code 2, first
        vec(1,0, 99,2,1,1,0),  // R3 code 2, second
        vec(0,1, 99,2,1,0,1),  // R7
        vec(1,0,300,3,1,0,1),  // R5 run 1
        vec(1,0,150,3,1,0,1),  // R5 inside resets run
        vec(1,0,300,3,1,0,1),  // R5 run 1
        vec(1,0,300,3,1,0,1),  // R5 run 2
        vec(0,0,300,3,1,0,1),  // R9 no cycle ignored
        vec(1,0,300,3,1,1,0),  // R5 run 3 trips
        vec(1,1,300,0,1,0,1),  // R7 clear wins over cycle
        vec(1,0,150,0,1,1,0),  // R4 code 0 inside still fires
        vec(0,1,150,0,1,0,1)   // R7
    };
    localparam int VREQ [NV] = '{7,2,2,2,2,6,8,7,3,3,7,5,5,5,5,9,5,7,4,7};

    function automatic int exp_len(input int c);
        case (c)
            0: return 0;   1: return 1;   2: return 2;   3: return 3;
            4: return 5;   5: return 10;  6: return 15;  7: return 20;
            8: return 25;  9: return 30;  10: return 35; 11: return 40;
            12: return 45; 13: return 50; 14: return 55; default: return 60;
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic step(input logic cd, input logic cl, input int v, input int c, input logic en);
        @(negedge clk);
        cycle_done = cd; clr_strobe = cl; clear_value = 16'(v);
        pers_code = 4'(c); int_en = en;
        @(posedge clk);
        #1;
        cycle_done = 1'b0; clr_strobe = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", int_status, 1'b0, "status after reset");
        chk("R1", int_n, 1'b1, "pin after reset");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][24], VEC[i][23], int'(VEC[i][22:7]), int'(VEC[i][6:3]), VEC[i][2]);
            chk($sformatf("R%0d", VREQ[i]), int_status, VEC[i][1], $sformatf("vec %0d status", i));
            chk($sformatf("R%0d", VREQ[i]), int_n, VEC[i][0], $sformatf("vec %0d pin", i));
        end

        // R3: every code's run length
        for (int c = 1; c < 16; c++) begin
            step(0, 1, 0, c, 1);
            for (int k = 1; k < exp_len(c); k++) step(1, 0, 500, c, 1);
            chk("R3", int_status, 1'b0, $sformatf("code %0d one short", c));
            step(1, 0, 5, c, 1);
            chk("R3", int_status, 1'b1, $sformatf("code %0d at length", c));
        end

        // R10: raise code mid-run, count kept
        step(0, 1, 0, 2, 1);
        step(1, 0, 500, 2, 1);
        for (int k = 0; k < 3; k++) step(1, 0, 500, 4, 1);
        chk("R10", int_status, 1'b0, "raised code, count 4 of 5");
        step(1, 0, 500, 4, 1);
        chk("R10", int_status, 1'b1, "raised code, count 5 of 5");

        // R10: lower code below current count
        step(0, 1, 0, 15, 1);
        for (int k = 0; k < 10; k++) step(1, 0, 500, 15, 1);
        chk("R10", int_status, 1'b0, "code 15 after 10");
        step(1, 0, 500, 2, 1);
        chk("R10", int_status, 1'b1, "lowered code trips");

        // R1: reset empties a partial run
        step(0, 1, 0, 3, 1);
        step(1, 0, 500, 3, 1);
        step(1, 0, 500, 3, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        step(1, 0, 500, 3, 1);
        step(1, 0, 500, 3, 1);
        chk("R1", int_status, 1'b0, "run restarted after reset");

        // R1: reset clears a set flag
        step(1, 0, 5, 0, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1", int_status, 1'b0, "flag cleared by reset");
        chk("R1", int_n, 1'b1, "pin released by reset");

        // R8: enable off during trip, flag still set
        step(1, 0, 5, 1, 0);
        chk("R8", int_status, 1'b1, "flag sets with enable off");
        chk("R8", int_n, 1'b1, "pin high with enable off");
        step(0, 0, 5, 1, 1);
        chk("R8", int_n, 1'b0, "pin low once enabled");

        // R9: thresholds move without a cycle, no effect
        step(0, 1, 0, 1, 1);
        @(negedge clk); thr_low = 16'd1000; thr_high = 16'd2000; clear_value = 16'd5;
        @(posedge clk); #1;
        chk("R9", int_status, 1'b0, "no cycle, no trip");
        thr_low = 16'd100; thr_high = 16'd200;

        finished = 1;
        summary();
    end
endmodule